// File: doc/BRIEF.md
# Edge-Triggered Vector Priority Arbiter

This block turns activity on up to eight external trigger pins into interrupt vector numbers. Each pin is synchronised and debounced. A level change that survives the selected debounce length counts as a rising or falling edge on that pin. Each direction of each pin has its own enable bit. An edge whose enable bit is clear is thrown away. An enabled edge waits in a pending set until it wins arbitration.

An initialization event has its own vector and beats everything else. Releasing reset raises it, and so does a pulse on a dedicated request input. A jump request brings its own vector and has the lowest priority. The winner is presented as a vector with a valid flag and held steady until the consumer acknowledges it. Events that arrive in the meantime stay pending and are delivered one per acknowledge, in priority order.

Top module: `trig_vec_arb`

## Requirements
- R1: During reset `vec_valid_o` is 0. After reset is released, the first vector presented is the initialization vector 32.
- R2: A one-cycle pulse on `init_req_i` makes vector 32 pending. When it competes with pending trigger edges, vector 32 is presented first.
- R3: While `vec_valid_o` is 1 and `vec_ack_i` is 0, `vec_o` and `vec_valid_o` hold their values. An acknowledge retires the presented vector.
- R4: For pin index n from 1 to 4, a falling edge gives vector n-1 and a rising edge gives vector n+3. For n from 5 to 8, a falling edge gives vector n+3 and a rising edge gives vector n+7.
- R5: Edge enables are two 8-bit registers, low (`en_lo_i`) and high (`en_hi_i`). Bit k of the 16-bit concatenation {high, low} enables the edge that maps to vector k, and 1 means enabled. Both registers reset to 8'hFF.
- R6: An edge detected while its enable bit is 0 is discarded. Setting the bit afterwards does not produce that edge.
- R7: Simultaneously pending trigger edges are served in this order: pin 1 falling, pin 1 rising, pin 2 falling, pin 2 rising, and so on up to pin 8 rising. A pin's rising edge beats a falling edge of any higher-numbered pin.
- R8: A jump request presents `jmp_vec_i` only when no initialization or trigger edge is pending. A jump request that arrives while an earlier jump is still pending is ignored.
- R9: With `deb_long_i` = 0 a level change must persist for DEB_SHORT consecutive samples, and with `deb_long_i` = 1 for DEB_LONG samples. A shorter pulse produces no edge.
- R10: Events that occur while a vector is presented are held pending and are all delivered later, one per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release raises the initialization event |
| init_req_i | input | 1 | Pulse that raises the initialization event |
| trig_i | input | NUM_PINS | Raw trigger pins, idle high |
| deb_long_i | input | 1 | 1 selects the long debounce length, 0 the short one |
| en_lo_we_i | input | 1 | Write strobe for the low enable register |
| en_lo_i | input | 8 | Write data, enables for vectors 0..7 |
| en_hi_we_i | input | 1 | Write strobe for the high enable register |
| en_hi_i | input | 8 | Write data, enables for vectors 8..15 |
| jmp_req_i | input | 1 | Jump request strobe |
| jmp_vec_i | input | VEC_W | Vector carried by the jump request |
| vec_valid_o | output | 1 | A vector is presented |
| vec_o | output | VEC_W | Presented vector |
| vec_ack_i | input | 1 | Consumer accepts the presented vector |

## Verification
The assertions check on every cycle that a presented vector is held until it is acknowledged. They also check that a pending initialization event always takes the free output slot, that a trigger edge always beats a pending jump, and that the output never stays empty while anything is pending. Only the bench scenarios can show the exact pin-to-vector mapping, the fall-before-rise interleave across pins, and the debounce filtering of short pulses under both length settings. The scenarios also show that a disabled edge is gone for good rather than deferred, and that a second jump request is dropped.

// File: rtl/trig_arb_pkg.sv
package trig_arb_pkg;

   localparam int EDGE_CNT = 16;
   localparam int MAX_PINS = 8;

   // Vector of the edge at arbitration rank r (rank 0 wins).
   // Even ranks are falling edges, odd ranks rising edges, pin = r/2.
   function automatic logic [3:0] vec_of_rank(input int rank);
      int pin;
      int rise;
      pin  = rank / 2;
      rise = rank % 2;
      return 4'((pin / 4) * 8 + rise * 4 + (pin % 4));
   endfunction

endpackage

// File: rtl/trig_debounce.sv
module trig_debounce #(
   parameter int   SYNC_STAGES = 2,
   parameter int   SHORT_LEN   = 1200,
   parameter int   LONG_LEN    = 150000,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic long_i,
   output logic level_o
);
   localparam int CNT_W = $clog2(LONG_LEN + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("trig_debounce: SYNC_STAGES must be at least 2");
   end
   if (SHORT_LEN < 1 || LONG_LEN < SHORT_LEN) begin : g_bad_len
      $error("trig_debounce: need 1 <= SHORT_LEN <= LONG_LEN");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       cnt_nxt;
   logic [CNT_W-1:0]       limit;
   logic                   level_q;
   logic                   samp;

   assign samp    = sync_q[SYNC_STAGES-1];
   assign limit   = long_i ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
   assign cnt_nxt = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= IDLE_LEVEL;
         cnt_q   <= '0;
      end else if (samp == level_q) begin
         cnt_q   <= '0;
      end else if (cnt_nxt >= limit) begin
         level_q <= samp;
         cnt_q   <= '0;
      end else begin
         cnt_q   <= cnt_nxt;
      end
   end

   assign level_o = level_q;

endmodule

// File: rtl/trig_edge_qual.sv
module trig_edge_qual #(
   parameter int   NUM_PINS   = 8,
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] level_i,
   input  logic [15:0]         en_i,
   output logic [15:0]         hit_o
);
   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= {NUM_PINS{IDLE_LEVEL}};
      end else begin
         prev_q <= level_i;
      end
   end

   for (genvar p = 0; p < trig_arb_pkg::MAX_PINS; p++) begin : g_pin
      localparam int FV = (p / 4) * 8 + (p % 4);
      localparam int RV = FV + 4;
      if (p < NUM_PINS) begin : g_used
         assign hit_o[FV] =  prev_q[p] & ~level_i[p] & en_i[FV];
         assign hit_o[RV] = ~prev_q[p] &  level_i[p] & en_i[RV];
      end else begin : g_unused
         assign hit_o[FV] = 1'b0;
         assign hit_o[RV] = 1'b0;
      end
   end

endmodule

// File: rtl/trig_prio_pick.sv
module trig_prio_pick (
   input  logic [15:0] pend_i,
   output logic        any_o,
   output logic [3:0]  vec_o
);
   import trig_arb_pkg::*;

   always_comb begin
      any_o = 1'b0;
      vec_o = '0;
      for (int r = EDGE_CNT - 1; r >= 0; r--) begin
         if (pend_i[vec_of_rank(r)]) begin
            any_o = 1'b1;
            vec_o = vec_of_rank(r);
         end
      end
   end

endmodule

// File: rtl/trig_vec_arb.sv
module trig_vec_arb #(
   parameter int   NUM_PINS    = 8,
   parameter int   VEC_W       = 11,
   parameter int   INIT_VEC    = 32,
   parameter int   SYNC_STAGES = 2,
   parameter int   DEB_SHORT   = 1200,
   parameter int   DEB_LONG    = 150000,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                init_req_i,
   input  logic [NUM_PINS-1:0] trig_i,
   input  logic                deb_long_i,
   input  logic                en_lo_we_i,
   input  logic [7:0]          en_lo_i,
   input  logic                en_hi_we_i,
   input  logic [7:0]          en_hi_i,
   input  logic                jmp_req_i,
   input  logic [VEC_W-1:0]    jmp_vec_i,
   output logic                vec_valid_o,
   output logic [VEC_W-1:0]    vec_o,
   input  logic                vec_ack_i
);
   import trig_arb_pkg::*;

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("trig_vec_arb: NUM_PINS out of range");
   end
   if (INIT_VEC < EDGE_CNT || INIT_VEC >= (1 << VEC_W)) begin : g_bad_init
      $error("trig_vec_arb: INIT_VEC must be above the edge vectors and fit VEC_W");
   end

   // enable registers
   logic [7:0]  en_lo_q, en_hi_q;
   logic [15:0] en_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_lo_q <= 8'hFF;
         en_hi_q <= 8'hFF;
      end else begin
         if (en_lo_we_i) en_lo_q <= en_lo_i;
         if (en_hi_we_i) en_hi_q <= en_hi_i;
      end
   end
   assign en_all = {en_hi_q, en_lo_q};

   // debounce per pin
   logic [NUM_PINS-1:0] level;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_deb
      trig_debounce #(
         .SYNC_STAGES (SYNC_STAGES),
         .SHORT_LEN   (DEB_SHORT),
         .LONG_LEN    (DEB_LONG),
         .IDLE_LEVEL  (IDLE_LEVEL)
      ) deb_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_i   (trig_i[p]),
         .long_i  (deb_long_i),
         .level_o (level[p])
      );
   end

   // edge detection and enable qualification
   logic [15:0] hit;

   trig_edge_qual #(
      .NUM_PINS   (NUM_PINS),
      .IDLE_LEVEL (IDLE_LEVEL)
   ) edge_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (level),
      .en_i    (en_all),
      .hit_o   (hit)
   );

   // pending state
   logic             pend_init;
   logic [15:0]      pend_edge;
   logic             pend_jmp;
   logic [VEC_W-1:0] jmp_vec_q;
   logic             pick_any;
   logic [3:0]       pick_vec;

   trig_prio_pick pick_i (
      .pend_i (pend_edge),
      .any_o  (pick_any),
      .vec_o  (pick_vec)
   );

   logic             out_valid_q;
   logic [VEC_W-1:0] out_vec_q;
   logic             take;
   logic             grant_init, grant_edge, grant_jmp;
   logic [15:0]      edge_clr;

   always_comb begin
      take       = !out_valid_q || vec_ack_i;
      grant_init = take && pend_init;
      grant_edge = take && !pend_init && pick_any;
      grant_jmp  = take && !pend_init && !pick_any && pend_jmp;
      edge_clr   = grant_edge ? (16'h0001 << pick_vec) : 16'h0000;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_init <= 1'b1;
         pend_edge <= '0;
      end else begin
         pend_init <= (pend_init && !grant_init) || init_req_i;
         pend_edge <= (pend_edge & ~edge_clr) | hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_jmp  <= 1'b0;
         jmp_vec_q <= '0;
      end else if (jmp_req_i && (!pend_jmp || grant_jmp)) begin
         pend_jmp  <= 1'b1;
         jmp_vec_q <= jmp_vec_i;
      end else if (grant_jmp) begin
         pend_jmp  <= 1'b0;
      end
   end

   // output slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         out_vec_q   <= '0;
      end else if (take) begin
         out_valid_q <= grant_init || grant_edge || grant_jmp;
         if (grant_init) begin
            out_vec_q <= VEC_W'(INIT_VEC);
         end else if (grant_edge) begin
            out_vec_q <= VEC_W'(pick_vec);
         end else if (grant_jmp) begin
            out_vec_q <= jmp_vec_q;
         end
      end
   end

   assign vec_valid_o = out_valid_q;
   assign vec_o       = out_vec_q;

endmodule

// File: rtl/trig_vec_arb_chk.sv
module trig_vec_arb_chk #(
   parameter int VEC_W    = 11,
   parameter int INIT_VEC = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vec_valid_o,
   input logic [VEC_W-1:0] vec_o,
   input logic             vec_ack_i,
   input logic             pend_init,
   input logic [15:0]      pend_edge,
   input logic             pend_jmp
);
   logic slot_free;
   assign slot_free = !vec_valid_o || vec_ack_i;

   AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o && !vec_ack_i |=> vec_valid_o && $stable(vec_o)); // R3

   AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      slot_free && pend_init |=> vec_valid_o && vec_o == VEC_W'(INIT_VEC)); // R2

   AST_EDGE_OVER_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      slot_free && !pend_init && (pend_edge != 16'h0) && pend_jmp |=> pend_jmp && vec_valid_o); // R8

   AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid_o && (pend_init || (pend_edge != 16'h0) || pend_jmp) |=> vec_valid_o); // R10

   AST_EDGE_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_free && !pend_init && (pend_edge != 16'h0) |=> vec_o < VEC_W'(16)); // R4

endmodule

bind trig_vec_arb trig_vec_arb_chk #(
   .VEC_W    (VEC_W),
   .INIT_VEC (INIT_VEC)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .vec_valid_o (vec_valid_o),
   .vec_o       (vec_o),
   .vec_ack_i   (vec_ack_i),
   .pend_init   (pend_init),
   .pend_edge   (pend_edge),
   .pend_jmp    (pend_jmp)
);

// File: tb/trig_vec_arb_tb_top.sv
module trig_vec_arb_tb_top;
   localparam int VEC_W = 11;
   localparam int DSH   = 4;
   localparam int DLG   = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             init_req = 1'b0;
   logic [7:0]       trig = 8'hFF;
   logic             deb_long = 1'b0;
   logic             en_lo_we = 1'b0, en_hi_we = 1'b0;
   logic [7:0]       en_lo = 8'hFF, en_hi = 8'hFF;
   logic             jmp_req = 1'b0;
   logic [VEC_W-1:0] jmp_vec = '0;
   logic             vec_valid;
   logic [VEC_W-1:0] vec;
   logic             vec_ack = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   trig_vec_arb #(
      .NUM_PINS (8), .VEC_W (VEC_W), .INIT_VEC (32),
      .DEB_SHORT (DSH), .DEB_LONG (DLG)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .init_req_i (init_req), .trig_i (trig),
      .deb_long_i (deb_long), .en_lo_we_i (en_lo_we), .en_lo_i (en_lo),
      .en_hi_we_i (en_hi_we), .en_hi_i (en_hi), .jmp_req_i (jmp_req),
      .jmp_vec_i (jmp_vec), .vec_valid_o (vec_valid), .vec_o (vec),
      .vec_ack_i (vec_ack)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_vec(input int exp, input string req);
      int n = 0;
      while (!vec_valid && n < 100) begin
         tick(1);
         n++;
      end
      check(vec_valid && int'(vec) == exp, req, vec_valid ? int'(vec) : -1, exp);
      vec_ack = 1'b1;
      tick(1);
      vec_ack = 1'b0;
   endtask

   task automatic expect_idle(input int n, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         tick(1);
         if (vec_valid) seen = 1'b1;
      end
      check(!seen, req, int'(seen), 0);
   endtask

   task automatic pin(input int p, input bit v, input int hold);
      trig[p-1] = v;
      tick(hold);
   endtask

   task automatic send_jump(input int v);
      jmp_vec = VEC_W'(v);
      jmp_req = 1'b1;
      tick(1);
      jmp_req = 1'b0;
   endtask

   task automatic t_reset;
      tick(3);
      check(vec_valid == 1'b0, "R1 reset valid", int'(vec_valid), 0);
      rst_n = 1'b1;
      tick(1);
      check(vec_valid && vec == VEC_W'(32), "R1 first vector", int'(vec), 32);
   endtask

   task automatic t_jump_drop;
      send_jump(11'h155);
      send_jump(11'h2AA);
      tick(2);
      check(vec_valid && vec == VEC_W'(32), "R3 hold without ack", int'(vec), 32);
      expect_vec(32, "R3 ack init");
      expect_vec(11'h155, "R8 jump vector");
      expect_idle(20, "R8 second jump ignored");
   endtask

   task automatic t_mapping;
      pin(1, 0, 0); expect_vec(0,  "R4 pin1 fall");
      pin(1, 1, 0); expect_vec(4,  "R4 pin1 rise");
      pin(5, 0, 0); expect_vec(8,  "R4 pin5 fall");
      pin(5, 1, 0); expect_vec(12, "R4 pin5 rise");
      pin(8, 0, 0); expect_vec(11, "R5 pin8 fall reset enables");
      pin(8, 1, 0); expect_vec(15, "R5 pin8 rise reset enables");
   endtask

   task automatic t_enables;
      en_lo = 8'h00; en_lo_we = 1'b1; tick(1); en_lo_we = 1'b0;
      pin(2, 0, 0);
      expect_idle(30, "R6 disabled fall dropped");
      en_lo = 8'hFF; en_lo_we = 1'b1; tick(1); en_lo_we = 1'b0;
      expect_idle(10, "R6 not deferred after enable");
      pin(2, 1, 0); expect_vec(5, "R6 later rise");
      en_hi = 8'b0001_0000; en_hi_we = 1'b1; tick(1); en_hi_we = 1'b0;
      pin(5, 0, 0);
      expect_idle(30, "R5 bit8 clear blocks pin5 fall");
      pin(5, 1, 0); expect_vec(12, "R5 bit12 set passes pin5 rise");
      en_hi = 8'hFF; en_hi_we = 1'b1; tick(1); en_hi_we = 1'b0;
   endtask

   task automatic t_priority;
      send_jump(11'h100);
      tick(2);
      pin(1, 0, 12);
      pin(1, 1, 12);
      trig[1] = 1'b0; trig[5] = 1'b0;
      tick(12);
      send_jump(11'h0AB);
      tick(4);
      expect_vec(11'h100, "R10 held jump");
      expect_vec(0,  "R7 pin1 fall first");
      expect_vec(4,  "R7 pin1 rise before pin2 fall");
      expect_vec(1,  "R7 pin2 fall");
      expect_vec(9,  "R7 pin6 fall");
      expect_vec(11'h0AB, "R8 jump last");
      trig[1] = 1'b1; trig[5] = 1'b1;
      expect_vec(5,  "R10 pin2 rise");
      expect_vec(13, "R10 pin6 rise");
   endtask

   task automatic t_init_req;
      send_jump(11'h040);
      tick(2);
      trig[3] = 1'b0;
      init_req = 1'b1; tick(1); init_req = 1'b0;
      tick(12);
      expect_vec(11'h040, "R2 held jump");
      expect_vec(32, "R2 init beats trigger");
      expect_vec(3,  "R2 trigger after init");
      pin(4, 1, 0); expect_vec(7, "R4 pin4 rise");
   endtask

   task automatic t_debounce;
      pin(3, 0, 2); pin(3, 1, 0);
      expect_idle(20, "R9 short glitch");
      deb_long = 1'b1;
      pin(3, 0, 7); pin(3, 1, 0);
      expect_idle(30, "R9 long mode filters 7 cycles");
      pin(3, 0, 0); expect_vec(2, "R9 long mode fall");
      pin(3, 1, 0); expect_vec(6, "R9 long mode rise");
      deb_long = 1'b0;
      expect_idle(20, "R9 no residue");
   endtask

   initial begin
      t_reset();
      t_jump_drop();
      t_mapping();
      t_enables();
      t_priority();
      t_init_req();
      t_debounce();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule